// File: doc/BRIEF.md
# Table-Programmed Bit-Serial Processing Element

This block is a single processing element of a SIMD pixel array. Every executed cycle it takes two source bits, i and j, plus the carry flag F, and looks the three bits up in a 16-bit function code supplied with the instruction. The table entry gives two bits: a result bit d, written to a chosen destination, and a new value for F. Any logic or arithmetic step of three inputs and two outputs is a table value, so wide additions, subtractions and comparisons are sequenced one bit per cycle by an outside controller, least significant bit first, with the carry or borrow held in F between cycles.

The element keeps eight one-bit flags (X, Y, Z, T, U, V, A, F) and a 256-bit local memory with one 8-bit address per instruction. A source can be a flag, the addressed memory bit, or one of the eight neighbour outputs. An output selector presents one local bit to the neighbours in the same cycle, which is also how the stored state is observed. With the condition bit set, only an element whose A flag is 1 changes state. Instructions are broadcast to the whole array in lock step, so the instruction inputs carry no back-pressure: a cycle with the execute input high is always consumed.

Top module: `lut_bit_pe`

## Requirements
- R1: After reset all eight flags and all 256 memory bits read 0.
- R2: The function code is indexed by k = 4*i + 2*j + F; bits [15-2k : 14-2k] hold the table pair for that k, the upper bit being the new F and the lower bit being d. Code 16'b0001011001101011 therefore adds i, j and F, giving sum in d and carry in F.
- R3: Source select codes: 0..7 pick flags X, Y, Z, T, U, V, A, F in that order; 8..15 pick neighbour inputs N, NE, E, SE, S, SW, W, NW (bits 0..7 of the neighbour bus); 16 picks memory bit at the instruction address; 17..31 read as 0.
- R4: The destination code uses the same encoding: 0..7 write d into that flag, 16 writes d into memory at the instruction address, and any other code discards d while F still takes its new value.
- R5: On every executed cycle F takes the table's new-F bit, except when the destination is F itself, in which case F takes d.
- R6: With the condition input high and A = 0 no flag and no memory bit changes; with A = 1, or with the condition input low, the instruction executes.
- R7: With the execute input low no flag and no memory bit changes.
- R8: The neighbour output shows, in the same cycle and without a clock edge, the bit named by the output select using the source encoding of R3, read from the current stored state.
- R9: An n-bit addition or subtraction run least significant bit first, starting from F = 0, leaves the n-bit wrapped result in memory and leaves F = 1 exactly when the result did not fit (carry out, or borrow out for a subtraction).
- R10: An instruction may read and write memory in the same cycle only at the single instruction address; read and write of that bit behave as a read of the old value followed by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Execute the presented instruction this cycle |
| cond_en | input | 1 | Restrict execution to elements with A = 1 |
| func_code | input | 16 | Truth table: new F and d for each of 8 input combinations |
| i_sel | input | 5 | Source code for operand i |
| j_sel | input | 5 | Source code for operand j |
| dst_sel | input | 5 | Destination code for d |
| mem_addr | input | 8 | Memory bit address shared by source and destination |
| out_sel | input | 5 | Code of the bit shown to the neighbours |
| nbr_in | input | 8 | Outputs of the eight neighbours, N at bit 0 round to NW at bit 7 |
| nbr_out | output | 1 | Bit presented to the neighbours |

## Verification
The hardest state to reach is the end of a multi-bit chain, where F after the last bit must reflect a carry or borrow that has rippled through many single-bit cycles. The stimulus gets there by first writing operands into memory bit by bit with constant tables, then copying each bit of one operand into X and combining it with the matching memory bit of the other, so that both source and destination use the single address. Operand pairs are chosen to overflow and not to overflow, and the result and F are then read back one bit at a time through the neighbour output selector, alongside a behavioural model compared on every cycle.

// File: rtl/lutpe_pkg.sv
package lutpe_pkg;
  localparam int FLAG_N   = 8;
  localparam int NBR_N    = 8;
  localparam int LUT_IN   = 3;
  localparam int LUT_ROWS = 1 << LUT_IN;
  localparam int FUNC_W   = 2 * LUT_ROWS;
  localparam int SEL_W    = 5;
  localparam int SEL_MEM  = FLAG_N + NBR_N;
  localparam int FLAG_A   = 6;
  localparam int FLAG_F   = 7;
endpackage

// File: rtl/lutpe_srcmux.sv
module lutpe_srcmux
  import lutpe_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [FLAG_N-1:0] flags,
  input  logic [NBR_N-1:0]  nbr,
  input  logic              mem_bit,
  output logic              bit_o
);
  localparam int N_CODES = 1 << SEL_W;

  logic [N_CODES-1:0] cand;

  generate
    for (genvar c = 0; c < N_CODES; c++) begin : g_code
      if (c < FLAG_N) begin : g_flag
        assign cand[c] = flags[c];
      end else if (c < FLAG_N + NBR_N) begin : g_nbr
        assign cand[c] = nbr[c-FLAG_N];
      end else if (c == SEL_MEM) begin : g_mem
        assign cand[c] = mem_bit;
      end else begin : g_zero
        assign cand[c] = 1'b0;
      end
    end
  endgenerate

  assign bit_o = cand[sel];
endmodule

// File: rtl/lutpe_lut.sv
module lutpe_lut
  import lutpe_pkg::*;
(
  input  logic [FUNC_W-1:0] code,
  input  logic              i_bit,
  input  logic              j_bit,
  input  logic              f_bit,
  output logic              d_bit,
  output logic              nf_bit
);
  logic [LUT_IN-1:0] row;
  logic [1:0]        pair;

  assign row = {i_bit, j_bit, f_bit};

  // row 0 sits in the top pair of the code
  always_comb begin
    pair = '0;
    for (int p = 0; p < LUT_ROWS; p++) begin
      if (row == LUT_IN'(p)) pair = code[FUNC_W-1-2*p -: 2];
    end
  end

  assign nf_bit = pair[1];
  assign d_bit  = pair[0];
endmodule

// File: rtl/lutpe_store.sv
module lutpe_store
  import lutpe_pkg::*;
#(
  parameter int MEM_BITS = 256,
  parameter int ADDR_W   = $clog2(MEM_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d_bit,
  input  logic              nf_bit,
  output logic [FLAG_N-1:0] flags_q,
  output logic [MEM_BITS-1:0] mem_q,
  output logic              mem_rd
);
  generate
    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
      logic bit_q;
      if (k == FLAG_F) begin : g_carry
        // a direct write of d outranks the table's carry output
        always_ff @(posedge clk) begin
          if (!rst_n)                          bit_q <= 1'b0;
          else if (we && dst_sel == SEL_W'(k)) bit_q <= d_bit;
          else if (we)                         bit_q <= nf_bit;
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rst_n)                          bit_q <= 1'b0;
          else if (we && dst_sel == SEL_W'(k)) bit_q <= d_bit;
        end
      end
      assign flags_q[k] = bit_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                mem_q <= '0;
    else if (we && dst_sel == SEL_W'(SEL_MEM)) mem_q[addr] <= d_bit;
  end

  assign mem_rd = mem_q[addr];
endmodule

// File: rtl/lut_bit_pe.sv
module lut_bit_pe
  import lutpe_pkg::*;
#(
  parameter int MEM_BITS = 256,
  parameter int ADDR_W   = $clog2(MEM_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic              cond_en,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [SEL_W-1:0]  i_sel,
  input  logic [SEL_W-1:0]  j_sel,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [SEL_W-1:0]  out_sel,
  input  logic [NBR_N-1:0]  nbr_in,
  output logic              nbr_out
);
  logic [FLAG_N-1:0]   flags_q;
  logic [MEM_BITS-1:0] mem_q;
  logic                mem_rd;
  logic                opnd_i, opnd_j;
  logic                res_d, res_f;
  logic                exec_en;

  assign exec_en = op_en && (!cond_en || flags_q[FLAG_A]);

  lutpe_srcmux u_mux_i (
    .sel(i_sel), .flags(flags_q), .nbr(nbr_in), .mem_bit(mem_rd), .bit_o(opnd_i)
  );

  lutpe_srcmux u_mux_j (
    .sel(j_sel), .flags(flags_q), .nbr(nbr_in), .mem_bit(mem_rd), .bit_o(opnd_j)
  );

  lutpe_srcmux u_mux_out (
    .sel(out_sel), .flags(flags_q), .nbr(nbr_in), .mem_bit(mem_rd), .bit_o(nbr_out)
  );

  lutpe_lut u_lut (
    .code(func_code), .i_bit(opnd_i), .j_bit(opnd_j), .f_bit(flags_q[FLAG_F]),
    .d_bit(res_d), .nf_bit(res_f)
  );

  lutpe_store #(.MEM_BITS(MEM_BITS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(exec_en), .dst_sel(dst_sel), .addr(mem_addr),
    .d_bit(res_d), .nf_bit(res_f), .flags_q(flags_q), .mem_q(mem_q), .mem_rd(mem_rd)
  );
endmodule

// File: rtl/lutpe_chk.sv
module lutpe_chk
  import lutpe_pkg::*;
#(
  parameter int MEM_BITS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_en,
  input logic                cond_en,
  input logic [FUNC_W-1:0]   func_code,
  input logic [SEL_W-1:0]    dst_sel,
  input logic [FLAG_N-1:0]   flags_q,
  input logic [MEM_BITS-1:0] mem_q
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(flags_q) && $stable(mem_q))); // R7

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && cond_en && !flags_q[FLAG_A]) |=> ($stable(flags_q) && $stable(mem_q))); // R6

  AST_MEM_ONLY_BY_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel != SEL_W'(SEL_MEM)) |=> $stable(mem_q)); // R4

  AST_SINGLE_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(flags_q[FLAG_N-2:0] ^ $past(flags_q[FLAG_N-2:0])) <= 1)); // R4

  AST_SINGLE_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(mem_q ^ $past(mem_q)) <= 1)); // R10

  AST_ZERO_TABLE_CLEARS_F: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !cond_en && func_code == '0 && dst_sel == SEL_W'(FLAG_F))
      |=> !flags_q[FLAG_F]); // R5
endmodule

bind lut_bit_pe lutpe_chk #(.MEM_BITS(MEM_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .cond_en(cond_en),
  .func_code(func_code), .dst_sel(dst_sel), .flags_q(flags_q), .mem_q(mem_q)
);

// File: tb/test_lut_bit_pe.sv
module test_lut_bit_pe;
  import lutpe_pkg::*;

  localparam logic [15:0] ADC = 16'b0001011001101011;
  localparam logic [4:0] C_X = 5'd0, C_Y = 5'd1, C_Z = 5'd2, C_A = 5'd6, C_F = 5'd7;
  localparam logic [4:0] C_MEM = 5'd16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_en = 1'b0, cond_en = 1'b0;
  logic [15:0] func_code = '0;
  logic [4:0] i_sel = '0, j_sel = '0, dst_sel = '0, out_sel = '0;
  logic [7:0] mem_addr = '0, nbr_in = '0;
  logic nbr_out;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0]   rf = '0;
  logic [255:0] rm = '0;

  always #10 clk = ~clk;

  lut_bit_pe i_lut_bit_pe (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .cond_en(cond_en), .func_code(func_code),
    .i_sel(i_sel), .j_sel(j_sel), .dst_sel(dst_sel), .mem_addr(mem_addr),
    .out_sel(out_sel), .nbr_in(nbr_in), .nbr_out(nbr_out)
  );

  function automatic logic [15:0] mk(input int kind);
    logic [15:0] c = '0;
    for (int p = 0; p < 8; p++) begin
      logic i = p[2], j = p[1], f = p[0];
      logic d, nf;
      case (kind)
        1: begin d = i ^ j ^ f; nf = (!i && j) || (!i && f) || (j && f); end // subtract
        2: begin d = i; nf = f; end    // copy i
        3: begin d = 1'b1; nf = f; end // set
        default: begin d = 1'b0; nf = f; end // clear
      endcase
      c[15-2*p -: 2] = {nf, d};
    end
    return c;
  endfunction

  function automatic logic src_of(input logic [4:0] c, input logic [7:0] ad);
    if (c < 5'd8)       return rf[c[2:0]];
    else if (c < 5'd16) return nbr_in[c[2:0]];
    else if (c == 5'd16) return rm[ad];
    return 1'b0;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic [15:0] fc, input logic [4:0] si, sj, sd,
                     input logic [7:0] ad, input logic ce, input logic [4:0] os,
                     input logic has_exp, input logic exp, input string tag);
    logic vi, vj, d, nf, run;
    logic [2:0] row;
    logic [1:0] pair;
    op_en = en; func_code = fc; i_sel = si; j_sel = sj; dst_sel = sd;
    mem_addr = ad; cond_en = ce; out_sel = os;
    #2;
    chk(nbr_out, src_of(os, ad), "R8 model");
    if (has_exp) chk(nbr_out, exp, tag);
    vi = src_of(si, ad); vj = src_of(sj, ad);
    row = {vi, vj, rf[7]};
    pair = fc[15-2*row -: 2];
    d = pair[0]; nf = pair[1];
    run = en && (!ce || rf[6]);
    @(posedge clk);
    if (run) begin
      if (sd == C_F) rf[7] = d;
      else begin
        rf[7] = nf;
        if (sd < 5'd8) rf[sd[2:0]] = d;
        else if (sd == C_MEM) rm[ad] = d;
      end
    end
    @(negedge clk);
  endtask

  task automatic op(input logic [15:0] fc, input logic [4:0] si, sj, sd,
                    input logic [7:0] ad, input logic ce);
    cyc(1'b1, fc, si, sj, sd, ad, ce, C_F, 1'b0, 1'b0, "");
  endtask

  task automatic peek(input logic [4:0] os, input logic [7:0] ad, input logic exp,
                      input string tag);
    cyc(1'b0, 16'h0, 5'd0, 5'd0, 5'd0, ad, 1'b0, os, 1'b1, exp, tag);
  endtask

  task automatic load8(input logic [7:0] base, input logic [7:0] v);
    for (int k = 0; k < 8; k++)
      op(v[k] ? mk(3) : mk(4), 5'd0, 5'd0, C_MEM, base + 8'(k), 1'b0);
  endtask

  // dst[k] <= dst[k] + src[k], LSB first
  task automatic add8(input logic [7:0] src, input logic [7:0] dst);
    op(16'h0000, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      op(mk(2), C_MEM, 5'd0, C_X, src + 8'(k), 1'b0);
      op(ADC, C_X, C_MEM, C_MEM, dst + 8'(k), 1'b0);
    end
  endtask

  // dst[k] <= dst[k] - src[k], LSB first
  task automatic sub8(input logic [7:0] src, input logic [7:0] dst);
    op(16'h0000, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      op(mk(2), C_MEM, 5'd0, C_X, src + 8'(k), 1'b0);
      op(mk(1), C_MEM, C_X, C_MEM, dst + 8'(k), 1'b0);
    end
  endtask

  task automatic read8(input logic [7:0] base, input logic [7:0] exp, input logic expf);
    for (int k = 0; k < 8; k++) peek(C_MEM, base + 8'(k), exp[k], "R9 result bit (R10 same address)");
    peek(C_F, 8'd0, expf, "R9 overflow flag");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int k = 0; k < 8; k++) peek(5'(k), 8'd0, 1'b0, "R1 flag after reset");
    peek(C_MEM, 8'd0, 1'b0, "R1 memory low");
    peek(C_MEM, 8'd255, 1'b0, "R1 memory high");

    // R2: single ADC step, 1+1+1 -> d=1, F=1
    op(mk(3), 5'd0, 5'd0, C_X, 8'd0, 1'b0);
    op(mk(3), 5'd0, 5'd0, C_Y, 8'd0, 1'b0);
    op(16'h5555, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    op(ADC, C_X, C_Y, C_Z, 8'd0, 1'b0);
    peek(C_Z, 8'd0, 1'b1, "R2 adc sum");
    peek(C_F, 8'd0, 1'b1, "R2 adc carry");
    // 1+0+0 -> d=1, F=0
    op(mk(4), 5'd0, 5'd0, C_Y, 8'd0, 1'b0);
    op(16'h0000, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    op(ADC, C_X, C_Y, C_Z, 8'd0, 1'b0);
    peek(C_Z, 8'd0, 1'b1, "R2 adc sum one");
    peek(C_F, 8'd0, 1'b0, "R2 adc no carry");

    // R9 / R10: multi-bit arithmetic
    load8(8'd0, 8'd200); load8(8'd8, 8'd100);
    add8(8'd0, 8'd8);
    read8(8'd8, 8'd44, 1'b1);
    load8(8'd16, 8'd17); load8(8'd24, 8'd35);
    add8(8'd16, 8'd24);
    read8(8'd24, 8'd52, 1'b0);
    load8(8'd32, 8'd50); load8(8'd40, 8'd80);
    sub8(8'd40, 8'd32);
    read8(8'd32, 8'd226, 1'b1);
    load8(8'd48, 8'd90); load8(8'd56, 8'd20);
    sub8(8'd56, 8'd48);
    read8(8'd48, 8'd70, 1'b0);

    // R3: neighbour sources and unused code
    nbr_in = 8'b1010_0101;
    op(mk(2), 5'd8, 5'd0, C_Y, 8'd0, 1'b0);
    peek(C_Y, 8'd0, 1'b1, "R3 copy north neighbour");
    op(mk(2), 5'd14, 5'd0, C_Y, 8'd0, 1'b0);
    peek(C_Y, 8'd0, 1'b0, "R3 copy west neighbour");
    peek(5'd11, 8'd0, 1'b0, "R8 echo south-east neighbour");
    peek(5'd15, 8'd0, 1'b1, "R8 echo north-west neighbour");
    op(mk(3), 5'd0, 5'd0, C_Z, 8'd0, 1'b0);
    op(mk(2), 5'd20, 5'd0, C_Z, 8'd0, 1'b0);
    peek(C_Z, 8'd0, 1'b0, "R3 unused source reads zero");

    // R4: unused destination discards d, F still updates
    op(mk(3), 5'd0, 5'd0, C_X, 8'd0, 1'b0);
    op(16'h0000, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    op(16'hAAAA, 5'd0, 5'd0, 5'd25, 8'd0, 1'b0);
    peek(C_X, 8'd0, 1'b1, "R4 flag untouched by discard");
    peek(C_F, 8'd0, 1'b1, "R4 carry still updated");

    // R5: d wins when destination is F
    op(16'h5555, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    peek(C_F, 8'd0, 1'b1, "R5 d written into F");
    op(16'hAAAA, 5'd0, 5'd0, C_F, 8'd0, 1'b0);
    peek(C_F, 8'd0, 1'b0, "R5 d over carry");

    // R6: conditional execution on A
    op(mk(4), 5'd0, 5'd0, C_A, 8'd0, 1'b0);
    op(mk(4), 5'd0, 5'd0, C_X, 8'd0, 1'b0);
    op(mk(3), 5'd0, 5'd0, C_X, 8'd0, 1'b1);
    peek(C_X, 8'd0, 1'b0, "R6 masked flag write");
    op(mk(3), 5'd0, 5'd0, C_MEM, 8'd100, 1'b1);
    peek(C_MEM, 8'd100, 1'b0, "R6 masked memory write");
    op(16'hFFFF, 5'd0, 5'd0, C_Y, 8'd0, 1'b1);
    peek(C_F, 8'd0, 1'b0, "R6 masked carry hold");
    op(mk(3), 5'd0, 5'd0, C_A, 8'd0, 1'b0);
    op(mk(3), 5'd0, 5'd0, C_X, 8'd0, 1'b1);
    peek(C_X, 8'd0, 1'b1, "R6 enabled flag write");

    // R7: idle cycle changes nothing
    cyc(1'b0, mk(4), 5'd0, 5'd0, C_X, 8'd0, 1'b0, C_X, 1'b1, 1'b1, "R7 before idle");
    peek(C_X, 8'd0, 1'b1, "R7 flag kept when idle");
    cyc(1'b0, mk(3), 5'd0, 5'd0, C_MEM, 8'd200, 1'b0, C_MEM, 1'b1, 1'b0, "R7 before idle mem");
    peek(C_MEM, 8'd200, 1'b0, "R7 memory kept when idle");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule